// File: doc/BRIEF.md
# Single-Bit Hamming ECC Engine

This block builds a 24-bit Hamming check code over a chunk of data bytes as they pass through a flash interface. It keeps one independent accumulation context for each chip select. A byte enters the context named by its chip-select tag, and only if that context has been armed by a start pulse. The code can correct one bit in a chunk.

A read request for one context does three things. It returns the packed, inverted code for that context. It compares that code with a stored code given alongside the request and classifies the difference. It then empties and disarms the context. On a write, software keeps the returned code and ignores the class. On a read, software uses the class and the reported byte and bit position to patch its buffer. Storing the code in flash and patching data are done outside this block.

The code is arranged so that a fully erased chunk (every byte 0xFF) yields a code of all ones. That code matches an erased spare area.

Top module: `sbecc_engine`

## Requirements
- R1: After reset, `rd_done` is low and every context is empty and disarmed. A read of any context then returns code 0xFFFFFF.
- R2: A pulse on `start[n]` empties context n and arms it. Bytes tagged for a disarmed context are ignored, so a later read of that context still returns 0xFFFFFF.
- R3: Data bit j of byte b has bit address a = 8*b + j. For every address bit k that is 1, that data bit toggles bit k of the upper parity half. For every address bit k that is 0, it toggles bit k of the lower parity half.
- R4: `code_out` is the bitwise inverse of {upper half, lower half}, with the upper half in bits 23:12 and the lower half in bits 11:0.
- R5: A full 512-byte chunk of 0xFF yields code 0xFFFFFF.
- R6: Contexts accumulate independently when their bytes are interleaved cycle by cycle.
- R7: A read request produces `rd_done` and its results at the next clock edge. The same edge empties and disarms the context, so a second read returns 0xFFFFFF.
- R8: The difference is the computed code XOR `stored_code`. A difference of zero gives class 0 (clean), with `fix_byte` and `fix_bit` at 0.
- R9: If the upper 12 bits of the difference XOR the lower 12 bits give all ones, the class is 1 (data bit fix). In that case `fix_byte` = difference bits 23:15 and `fix_bit` = difference bits 14:12.
- R10: A fix whose byte index is CHUNK_BYTES or more is reported as class 3 instead.
- R11: A difference with exactly one bit set gives class 2 (check-code bit error, data intact), with `fix_byte` and `fix_bit` at 0.
- R12: Any other nonzero difference gives class 3 (uncorrectable), with `fix_byte` and `fix_bit` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | NUM_CS | One-cycle arm-and-empty pulse per context |
| din_valid | input | 1 | Data byte present |
| din_cs | input | CS_W | Context tag of the data byte |
| din | input | 8 | Data byte |
| rd_req | input | 1 | Read, compare and empty one context |
| rd_cs | input | CS_W | Context to read |
| stored_code | input | CODE_W | Check code from flash for the comparison |
| rd_done | output | 1 | Results valid for one cycle |
| code_out | output | CODE_W | Packed, inverted code of the context |
| res_class | output | 2 | 0 clean, 1 data fix, 2 code-bit error, 3 uncorrectable |
| fix_byte | output | BYTE_W | Byte index to patch (class 1 only) |
| fix_bit | output | 3 | Bit index to patch (class 1 only) |

## Verification
A byte is folded in at the rising edge where `din_valid` is seen. A start or a read acts at the rising edge where it is asserted. `code_out`, `res_class` and the fix position are registered, so they are valid just after the edge that sampled `rd_req`. The bench drives every input just after a falling edge and reads the results at the following falling edge, which is one rising edge later and the first point at which the result is due. Code values are predicted by a bit-address model of the streamed bytes. Classes are predicted by choosing a stored code that produces the wanted difference against a freshly emptied context.

// File: rtl/sbecc_pkg.sv
package sbecc_pkg;

   typedef enum logic [1:0] {
      ECC_CLEAN    = 2'd0,
      ECC_DATA_FIX = 2'd1,
      ECC_CODE_BIT = 2'd2,
      ECC_FATAL    = 2'd3
   } ecc_class_e;

   function automatic int half_width(input int chunk_bytes);
      return $clog2(chunk_bytes * 8);
   endfunction

endpackage

// File: rtl/sbecc_byte_fold.sv
// Parity contribution of one byte at a given byte index.
module sbecc_byte_fold #(
   parameter int HALF_W = 12,
   localparam int BYTE_W = HALF_W - 3
) (
   input  logic [BYTE_W-1:0] byte_idx_i,
   input  logic [7:0]        byte_i,
   output logic [HALF_W-1:0] up_o,
   output logic [HALF_W-1:0] lo_o
);
   logic par;

   always_comb begin
      up_o = '0;
      lo_o = '0;
      par  = ^byte_i;
      // address bits 2:0 come from the bit position inside the byte
      for (int j = 0; j < 8; j++) begin
         for (int k = 0; k < 3; k++) begin
            if (((j >> k) & 1) != 0) up_o[k] = up_o[k] ^ byte_i[j];
            else                     lo_o[k] = lo_o[k] ^ byte_i[j];
         end
      end
      // higher address bits are shared by all eight bits of the byte
      for (int k = 3; k < HALF_W; k++) begin
         if (byte_idx_i[k-3]) up_o[k] = par;
         else                 lo_o[k] = par;
      end
   end
endmodule

// File: rtl/sbecc_context.sv
// One per-chip-select accumulation context.
module sbecc_context #(
   parameter int CHUNK_BYTES = 512,
   localparam int HALF_W = sbecc_pkg::half_width(CHUNK_BYTES),
   localparam int BYTE_W = HALF_W - 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              clr_i,
   input  logic              byte_en_i,
   input  logic [7:0]        byte_i,
   output logic [HALF_W-1:0] up_o,
   output logic [HALF_W-1:0] lo_o
);
   localparam logic [BYTE_W-1:0] LAST_IDX = BYTE_W'(CHUNK_BYTES - 1);

   logic              active_q;
   logic [BYTE_W-1:0] cnt_q;
   logic [HALF_W-1:0] up_q, lo_q;
   logic [HALF_W-1:0] up_d, lo_d;

   sbecc_byte_fold #(.HALF_W(HALF_W)) u_fold (
      .byte_idx_i (cnt_q),
      .byte_i     (byte_i),
      .up_o       (up_d),
      .lo_o       (lo_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
         up_q     <= '0;
         lo_q     <= '0;
      end else if (start_i) begin
         active_q <= 1'b1;
         cnt_q    <= '0;
         up_q     <= '0;
         lo_q     <= '0;
      end else if (clr_i) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
         up_q     <= '0;
         lo_q     <= '0;
      end else if (active_q && byte_en_i) begin
         up_q  <= up_q ^ up_d;
         lo_q  <= lo_q ^ lo_d;
         cnt_q <= (cnt_q == LAST_IDX) ? '0 : cnt_q + 1'b1;
      end
   end

   assign up_o = up_q;
   assign lo_o = lo_q;

   // R2: a disarmed context keeps its parity halves
   a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_q && !start_i && !clr_i) |=> ($stable(up_q) && $stable(lo_q)));

   // R7: a read leaves the context empty and disarmed
   a_r7_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !start_i) |=> (up_q == '0 && lo_q == '0 && !active_q));
endmodule

// File: rtl/sbecc_classify.sv
// Compares computed and stored codes and grades the difference.
module sbecc_classify #(
   parameter int CHUNK_BYTES = 512,
   localparam int HALF_W = sbecc_pkg::half_width(CHUNK_BYTES),
   localparam int CODE_W = 2 * HALF_W,
   localparam int BYTE_W = HALF_W - 3
) (
   input  logic [CODE_W-1:0]      calc_i,
   input  logic [CODE_W-1:0]      stored_i,
   output sbecc_pkg::ecc_class_e  class_o,
   output logic [BYTE_W-1:0]      byte_o,
   output logic [2:0]             bit_o
);
   import sbecc_pkg::*;

   logic [CODE_W-1:0] diff;
   logic [HALF_W-1:0] halves;
   logic [BYTE_W-1:0] pos_byte;

   assign diff     = calc_i ^ stored_i;
   assign halves   = diff[CODE_W-1:HALF_W] ^ diff[HALF_W-1:0];
   assign pos_byte = diff[CODE_W-1:HALF_W+3];

   always_comb begin
      class_o = ECC_FATAL;
      byte_o  = '0;
      bit_o   = '0;
      if (diff == '0) begin
         class_o = ECC_CLEAN;
      end else if (&halves) begin
         if ({1'b0, pos_byte} < CHUNK_BYTES[BYTE_W:0]) begin
            class_o = ECC_DATA_FIX;
            byte_o  = pos_byte;
            bit_o   = diff[HALF_W+2:HALF_W];
         end
      end else if ($onehot(diff)) begin
         class_o = ECC_CODE_BIT;
      end
   end
endmodule

// File: rtl/sbecc_engine.sv
module sbecc_engine #(
   parameter int NUM_CS      = 4,
   parameter int CHUNK_BYTES = 512,
   localparam int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
   localparam int HALF_W = sbecc_pkg::half_width(CHUNK_BYTES),
   localparam int CODE_W = 2 * HALF_W,
   localparam int BYTE_W = HALF_W - 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CS-1:0] start,
   input  logic              din_valid,
   input  logic [CS_W-1:0]   din_cs,
   input  logic [7:0]        din,
   input  logic              rd_req,
   input  logic [CS_W-1:0]   rd_cs,
   input  logic [CODE_W-1:0] stored_code,
   output logic              rd_done,
   output logic [CODE_W-1:0] code_out,
   output logic [1:0]        res_class,
   output logic [BYTE_W-1:0] fix_byte,
   output logic [2:0]        fix_bit
);
   import sbecc_pkg::*;

   generate
      if (NUM_CS < 1) begin : g_bad_cs
         $error("sbecc_engine: NUM_CS must be at least 1");
      end
      if (CHUNK_BYTES < 2) begin : g_bad_chunk
         $error("sbecc_engine: CHUNK_BYTES must be at least 2");
      end
   endgenerate

   logic [HALF_W-1:0] up_all [NUM_CS];
   logic [HALF_W-1:0] lo_all [NUM_CS];

   genvar g;
   generate
      for (g = 0; g < NUM_CS; g++) begin : g_ctx
         sbecc_context #(.CHUNK_BYTES(CHUNK_BYTES)) u_ctx (
            .clk       (clk),
            .rst_n     (rst_n),
            .start_i   (start[g]),
            .clr_i     (rd_req && (rd_cs == CS_W'(g))),
            .byte_en_i (din_valid && (din_cs == CS_W'(g))),
            .byte_i    (din),
            .up_o      (up_all[g]),
            .lo_o      (lo_all[g])
         );
      end
   endgenerate

   logic [CODE_W-1:0] calc_code;
   ecc_class_e        cls_d;
   logic [BYTE_W-1:0] byte_d;
   logic [2:0]        bit_d;

   assign calc_code = ~{up_all[rd_cs], lo_all[rd_cs]};

   sbecc_classify #(.CHUNK_BYTES(CHUNK_BYTES)) u_cls (
      .calc_i   (calc_code),
      .stored_i (stored_code),
      .class_o  (cls_d),
      .byte_o   (byte_d),
      .bit_o    (bit_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_done   <= 1'b0;
         code_out  <= '0;
         res_class <= '0;
         fix_byte  <= '0;
         fix_bit   <= '0;
      end else begin
         rd_done <= rd_req;
         if (rd_req) begin
            code_out  <= calc_code;
            res_class <= cls_d;
            fix_byte  <= byte_d;
            fix_bit   <= bit_d;
         end
      end
   end

   // R7: results appear only on the edge after a request
   a_r7_done_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |-> $past(rd_req));

   // R8: a clean verdict means the returned code equals the stored one
   a_r8_clean_matches: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_done && res_class == 2'd0) |-> (code_out == $past(stored_code)));

   // R11: a check-code verdict means one differing bit
   a_r11_code_bit_single: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_done && res_class == 2'd2) |-> ($countones(code_out ^ $past(stored_code)) == 1));

   // R10: a reported fix always lies inside the chunk
   a_r10_fix_in_chunk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_done && res_class == 2'd1) |-> ({1'b0, fix_byte} < CHUNK_BYTES[BYTE_W:0]));
endmodule

// File: tb/sbecc_engine_bench.sv
module sbecc_engine_bench;
   localparam int NCS = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  start = '0;
   logic        din_valid = 1'b0;
   logic [1:0]  din_cs = '0;
   logic [7:0]  din = '0;
   logic        rd_req = 1'b0;
   logic [1:0]  rd_cs = '0;
   logic [23:0] stored_code = '0;
   logic        rd_done, o_done;
   logic [23:0] code_out, o_code;
   logic [1:0]  res_class, o_class;
   logic [8:0]  fix_byte, o_byte;
   logic [2:0]  fix_bit, o_bit;

   int n_chk = 0;
   int n_fail = 0;

   logic [7:0] mem_a [512];
   logic [7:0] mem_b [512];

   always #5 clk = ~clk;

   sbecc_engine #(.NUM_CS(NCS), .CHUNK_BYTES(512)) u_sbecc_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .din_valid(din_valid),
      .din_cs(din_cs), .din(din), .rd_req(rd_req), .rd_cs(rd_cs),
      .stored_code(stored_code), .rd_done(rd_done), .code_out(code_out),
      .res_class(res_class), .fix_byte(fix_byte), .fix_bit(fix_bit)
   );

   // small-chunk variant so that out-of-range fix positions exist
   sbecc_engine #(.NUM_CS(NCS), .CHUNK_BYTES(320)) u_sbecc_engine_odd (
      .clk(clk), .rst_n(rst_n), .start(start), .din_valid(din_valid),
      .din_cs(din_cs), .din(din), .rd_req(rd_req), .rd_cs(rd_cs),
      .stored_code(stored_code), .rd_done(o_done), .code_out(o_code),
      .res_class(o_class), .fix_byte(o_byte), .fix_bit(o_bit)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] model_code(input logic [7:0] d [512], input int n);
      logic [11:0] u = '0;
      logic [11:0] l = '0;
      for (int b = 0; b < n; b++) begin
         for (int j = 0; j < 8; j++) begin
            if (d[b][j]) begin
               int a;
               a = b * 8 + j;
               for (int k = 0; k < 12; k++) begin
                  if (((a >> k) & 1) != 0) u[k] = ~u[k];
                  else                     l[k] = ~l[k];
               end
            end
         end
      end
      return ~{u, l};
   endfunction

   task automatic pulse_start(input logic [3:0] m);
      @(negedge clk); start = m;
      @(negedge clk); start = '0;
   endtask

   task automatic stream(input logic [7:0] d [512], input int n, input logic [1:0] cs);
      for (int b = 0; b < n; b++) begin
         @(negedge clk); din_valid = 1'b1; din_cs = cs; din = d[b];
      end
      @(negedge clk); din_valid = 1'b0;
   endtask

   // request at one edge, results sampled at the following falling edge
   task automatic do_read(input logic [1:0] cs, input logic [23:0] st);
      @(negedge clk); rd_req = 1'b1; rd_cs = cs; stored_code = st;
      @(negedge clk); rd_req = 1'b0;
   endtask

   task automatic expect_res(input string req, input logic [23:0] c,
                             input logic [1:0] cl, input int by, input int bi);
      check({req, " done"}, 32'(rd_done), 32'd1);
      check({req, " code"}, 32'(code_out), 32'(c));
      check({req, " class"}, 32'(res_class), 32'(cl));
      check({req, " byte"}, 32'(fix_byte), 32'(by));
      check({req, " bit"}, 32'(fix_bit), 32'(bi));
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_fail++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      summary();
   end

   initial begin
      int pos_b [6] = '{0, 0, 1, 37, 255, 511};
      int pos_j [6] = '{0, 7, 3, 5, 1, 6};
      logic [23:0] good;

      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 done low in reset", 32'(rd_done), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 done low after reset", 32'(rd_done), 32'd0);
      for (int c = 0; c < NCS; c++) begin
         do_read(2'(c), 24'hFFFFFF);
         expect_res("R1 empty context", 24'hFFFFFF, 2'd0, 0, 0);
      end

      // R2: bytes to a disarmed context are ignored
      for (int b = 0; b < 512; b++) mem_a[b] = 8'h5A;
      stream(mem_a, 5, 2'd1);
      do_read(2'd1, 24'hFFFFFF);
      expect_res("R2 disarmed ignores bytes", 24'hFFFFFF, 2'd0, 0, 0);

      // R3, R4, R9: one set bit at chosen addresses
      for (int p = 0; p < 6; p++) begin
         int a;
         a = pos_b[p] * 8 + pos_j[p];
         for (int b = 0; b < 512; b++) mem_a[b] = 8'h00;
         mem_a[pos_b[p]][pos_j[p]] = 1'b1;
         pulse_start(4'b0100);
         stream(mem_a, pos_b[p] + 1, 2'd2);
         do_read(2'd2, 24'hFFFFFF);
         expect_res("R3 R4 R9 single bit", ~{12'(a), ~12'(a)}, 2'd1, pos_b[p], pos_j[p]);
      end

      // R5: erased chunk
      for (int b = 0; b < 512; b++) mem_a[b] = 8'hFF;
      pulse_start(4'b1000);
      stream(mem_a, 512, 2'd3);
      do_read(2'd3, 24'hFFFFFF);
      expect_res("R5 erased chunk", 24'hFFFFFF, 2'd0, 0, 0);

      // R4, R8: random chunk matches model
      for (int b = 0; b < 512; b++) mem_a[b] = 8'($urandom);
      good = model_code(mem_a, 512);
      pulse_start(4'b0001);
      stream(mem_a, 512, 2'd0);
      do_read(2'd0, good);
      expect_res("R4 R8 random chunk", good, 2'd0, 0, 0);

      // R9: data with one flipped bit graded against the good code
      for (int f = 0; f < 3; f++) begin
         int fb, fj;
         fb = (f * 211 + 17) % 512;
         fj = (f * 3 + 2) % 8;
         mem_a[fb][fj] = ~mem_a[fb][fj];
         pulse_start(4'b0001);
         stream(mem_a, 512, 2'd0);
         do_read(2'd0, good);
         check("R9 flipped class", 32'(res_class), 32'd1);
         check("R9 flipped byte", 32'(fix_byte), 32'(fb));
         check("R9 flipped bit", 32'(fix_bit), 32'(fj));
         mem_a[fb][fj] = ~mem_a[fb][fj];
      end

      // R6: interleaved contexts
      for (int b = 0; b < 512; b++) begin
         mem_a[b] = 8'($urandom);
         mem_b[b] = 8'($urandom);
      end
      pulse_start(4'b0110);
      for (int b = 0; b < 64; b++) begin
         @(negedge clk); din_valid = 1'b1; din_cs = 2'd1; din = mem_a[b];
         @(negedge clk); din_valid = 1'b1; din_cs = 2'd2; din = mem_b[b];
      end
      @(negedge clk); din_valid = 1'b0;
      do_read(2'd1, 24'h0);
      check("R6 context 1 code", 32'(code_out), 32'(model_code(mem_a, 64)));
      do_read(2'd2, 24'h0);
      check("R6 context 2 code", 32'(code_out), 32'(model_code(mem_b, 64)));

      // R7: read empties and disarms
      do_read(2'd2, 24'hFFFFFF);
      expect_res("R7 second read empty", 24'hFFFFFF, 2'd0, 0, 0);
      stream(mem_b, 8, 2'd2);
      do_read(2'd2, 24'hFFFFFF);
      expect_res("R7 disarmed after read", 24'hFFFFFF, 2'd0, 0, 0);

      // R9: every single-data-bit difference
      for (int a = 0; a < 4096; a++) begin
         do_read(2'd0, 24'hFFFFFF ^ {12'(a), ~12'(a)});
         check("R9 sweep class", 32'(res_class), 32'd1);
         check("R9 sweep position", 32'({fix_byte, fix_bit}), 32'(a));
      end

      // R11: every one-hot difference
      for (int k = 0; k < 24; k++) begin
         do_read(2'd0, 24'hFFFFFF ^ (24'd1 << k));
         check("R11 one-hot class", 32'(res_class), 32'd2);
         check("R11 one-hot position", 32'({fix_byte, fix_bit}), 32'd0);
      end

      // R12: other nonzero differences
      begin
         logic [23:0] bad [5] = '{24'h000003, 24'hFFFFFF, 24'h00F00F, 24'h801000, 24'h123456};
         for (int i = 0; i < 5; i++) begin
            do_read(2'd0, 24'hFFFFFF ^ bad[i]);
            check("R12 uncorrectable class", 32'(res_class), 32'd3);
            check("R12 uncorrectable position", 32'({fix_byte, fix_bit}), 32'd0);
         end
      end

      // R10: fix beyond a 320-byte chunk
      do_read(2'd0, 24'hFFFFFF ^ {12'(3202), ~12'(3202)});
      check("R10 odd beyond chunk class", 32'(o_class), 32'd3);
      check("R10 odd beyond chunk done", 32'(o_done), 32'd1);
      check("R10 full chunk accepts byte 400", 32'({res_class, fix_byte}), 32'({2'd1, 9'd400}));
      do_read(2'd0, 24'hFFFFFF ^ {12'(2559), ~12'(2559)});
      check("R10 odd last byte class", 32'(o_class), 32'd1);
      check("R10 odd last byte pos", 32'({o_byte, o_bit}), 32'd2559);

      summary();
   end
endmodule